// File: doc/BRIEF.md
# Flash Status Register and Write-Permission Guard

This block keeps the status byte of a serial flash model and decides whether each write-type request may go ahead. The command decoder in front of it sends one-cycle strobes: latch set, latch clear, status write with a data byte, and array operations carrying an address and a kind. Each array operation is one of page program, small-sector erase, sector erase or chip erase. The block answers every array operation and status write with a one-cycle grant or reject pulse. A granted request starts a self-timed busy period whose length is a per-kind parameter, scaled down from the real durations.

Array protection uses a three-bit protect level. Status-register protection combines a stored lock bit with the level of the write-protect pin. The write-enable latch follows strict rules. It is set and cleared only by its own strobes. It is cleared automatically when a granted operation finishes. It is left untouched by any rejected request. The stored protect bits are plain flops with reset values; no flash cells are modelled.

Top module: `flash_stat_guard`

## Requirements
- R1: After reset the status byte reads 00h, busy is low, and grant and reject are low.
- R2: The status byte is laid out as follows: bit 0 is the busy flag (1 = operation running), bit 1 is the write-enable latch, bits 4:2 are the protect level (bit 4 is its MSB), bits 6:5 always read 0, and bit 7 is the status lock bit. The byte can be read at any time, including while busy.
- R3: A latch-set strobe sets the write-enable latch and a latch-clear strobe clears it. Both strobes are ignored while busy. If both arrive together, the clear wins.
- R4: An array operation or status write that arrives while the write-enable latch is 0 is rejected. It leaves every state unchanged and starts no busy period.
- R5: The protect level guards the array from the top address 7FFFFh down to a limit. Level 000 guards nothing, 001 guards from 70000h, 010 from 60000h, and 011 from 40000h. Any level with bit 2 set guards the whole array. A program or erase whose target address falls in the guarded range is rejected, and the write-enable latch keeps its value.
- R6: A chip erase (kind 11) is granted only when the protect level is 000.
- R7: A status write is rejected when the lock bit is 1 and the write-protect pin is low. When the pin is high, a status write is allowed whatever the lock bit holds.
- R8: A granted status write changes only the protect level and the lock bit, taken from data bits 4:2 and bit 7. Its other data bits are ignored. The new values appear in the status byte when the busy period ends.
- R9: A granted request keeps busy high for exactly the programmed number of cycles. The kinds and their defaults are: program, kind 00, 6 cycles; small-sector erase, kind 01, 10 cycles; sector erase, kind 10, 14 cycles; chip erase, kind 11, 20 cycles; status write, 5 cycles. The write-enable latch clears on the cycle that busy falls.
- R10: An array operation or status write that arrives while busy is rejected and changes no state.
- R11: On a grant, the reported target base address is aligned to the operation's unit. Program uses the full address, bits 18:0. Small-sector erase keeps bits 18:12 and zeroes the rest, giving 4 KB units. Sector erase keeps bits 18:16, giving 64 KB units. Chip erase reports 0.
- R12: Grant or reject is a single-cycle pulse, registered on the clock edge that samples the request. The two are never high together. Busy is high whenever grant is high.
- R13: If an array operation and a status write arrive in the same cycle, the array operation is the one handled and the status write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wen_set_i | input | 1 | Write-enable latch set strobe |
| wen_clr_i | input | 1 | Write-enable latch clear strobe |
| sr_wr_i | input | 1 | Status write strobe |
| sr_wdata_i | input | 8 | Status write data |
| op_req_i | input | 1 | Array operation request strobe |
| op_kind_i | input | 2 | 00 program, 01 small-sector erase, 10 sector erase, 11 chip erase |
| op_addr_i | input | ADDR_W (19) | Target byte address |
| wp_i | input | 1 | Write-protect pin level |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Self-timed operation running |
| grant_o | output | 1 | Request accepted pulse |
| reject_o | output | 1 | Request refused pulse |
| op_base_o | output | ADDR_W (19) | Aligned base of the last granted operation |
| op_kind_o | output | 2 | Kind of the last granted array operation |

## Verification
Array requests are driven with addresses one byte below and exactly at each protect limit for levels 001, 010 and 011. These pairs separate an off-by-one limit from a correct one, and the whole-array level is probed at address 0. Status writes are tried with every combination of lock bit and pin level that matters. Their data sets all reserved bits, which exposes any leak into the busy, latch or reserved fields. Requests and latch strobes issued in the middle of a busy period, together with cycle-exact busy lengths for each operation kind, distinguish a latch that clears on completion from one that clears on grant or on rejection.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SSEC = 2'b01,
        OP_SEC  = 2'b10,
        OP_CHIP = 2'b11
    } op_kind_e;

    localparam int LVL_W = 3;

endpackage

// File: rtl/fsg_prot_check.sv
module fsg_prot_check
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SSEC_W = 12,
    parameter int SEC_W  = 16
) (
    input  logic [LVL_W-1:0]  level_i,
    input  op_kind_e          kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_o,
    output logic              blocked_o
);
    localparam logic [ADDR_W-1:0] SSEC_MASK = {ADDR_W{1'b1}} << SSEC_W;
    localparam logic [ADDR_W-1:0] SEC_MASK  = {ADDR_W{1'b1}} << SEC_W;

    logic [2:0] eighth;
    logic [2:0] limit;
    logic       any_guard;
    logic       in_guard;

    always_comb begin
        case (kind_i)
            OP_SSEC: base_o = addr_i & SSEC_MASK;
            OP_SEC:  base_o = addr_i & SEC_MASK;
            OP_CHIP: base_o = '0;
            default: base_o = addr_i;
        endcase
    end

    assign eighth = base_o[ADDR_W-1 -: 3];

    always_comb begin
        any_guard = 1'b1;
        case (level_i)
            3'b000: begin limit = 3'd7; any_guard = 1'b0; end
            3'b001: limit = 3'd7;
            3'b010: limit = 3'd6;
            3'b011: limit = 3'd4;
            default: limit = 3'd0;
        endcase
    end

    assign in_guard  = any_guard && (eighth >= limit);
    assign blocked_o = (kind_i == OP_CHIP) ? (level_i != '0) : in_guard;

endmodule

// File: rtl/fsg_op_timer.sv
module fsg_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] dur_i,
    output logic             busy_o,
    output logic             done_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done_o = t_q.busy && (t_q.cnt == CNT_W'(1));
    assign busy_o = t_q.busy;

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = dur_i;
        end else if (done_o) begin
            t_d.busy = 1'b0;
            t_d.cnt  = '0;
        end else if (t_q.busy) begin
            t_d.cnt = t_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/flash_stat_guard.sv
module flash_stat_guard
    import fsg_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int SSEC_W   = 12,
    parameter int SEC_W    = 16,
    parameter int CNT_W    = 8,
    parameter int DUR_PROG = 6,
    parameter int DUR_SSEC = 10,
    parameter int DUR_SEC  = 14,
    parameter int DUR_CHIP = 20,
    parameter int DUR_SRW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_set_i,
    input  logic              wen_clr_i,
    input  logic              sr_wr_i,
    input  logic [7:0]        sr_wdata_i,
    input  logic              op_req_i,
    input  logic [1:0]        op_kind_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic              wp_i,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              grant_o,
    output logic              reject_o,
    output logic [ADDR_W-1:0] op_base_o,
    output logic [1:0]        op_kind_o
);
    localparam logic [CNT_W-1:0] D_PROG = CNT_W'(DUR_PROG);
    localparam logic [CNT_W-1:0] D_SSEC = CNT_W'(DUR_SSEC);
    localparam logic [CNT_W-1:0] D_SEC  = CNT_W'(DUR_SEC);
    localparam logic [CNT_W-1:0] D_CHIP = CNT_W'(DUR_CHIP);
    localparam logic [CNT_W-1:0] D_SRW  = CNT_W'(DUR_SRW);

    typedef struct packed {
        logic              wen;
        logic [LVL_W-1:0]  level;
        logic              lock;
        logic              pend;
        logic [LVL_W-1:0]  pend_level;
        logic              pend_lock;
        logic              grant;
        logic              reject;
        logic [ADDR_W-1:0] base;
        op_kind_e          kind;
    } st_t;

    st_t s_d, s_q;

    op_kind_e          req_kind;
    logic [ADDR_W-1:0] req_base;
    logic              req_blocked;
    logic              tmr_busy;
    logic              tmr_done;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_dur;
    logic [CNT_W-1:0]  kind_dur;

    assign req_kind = op_kind_e'(op_kind_i);

    fsg_prot_check #(
        .ADDR_W (ADDR_W),
        .SSEC_W (SSEC_W),
        .SEC_W  (SEC_W)
    ) u_prot (
        .level_i   (s_q.level),
        .kind_i    (req_kind),
        .addr_i    (op_addr_i),
        .base_o    (req_base),
        .blocked_o (req_blocked)
    );

    fsg_op_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .dur_i  (tmr_dur),
        .busy_o (tmr_busy),
        .done_o (tmr_done)
    );

    always_comb begin
        case (req_kind)
            OP_SSEC: kind_dur = D_SSEC;
            OP_SEC:  kind_dur = D_SEC;
            OP_CHIP: kind_dur = D_CHIP;
            default: kind_dur = D_PROG;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.grant  = 1'b0;
        s_d.reject = 1'b0;
        tmr_load = 1'b0;
        tmr_dur  = '0;

        if (tmr_done) begin
            s_d.wen = 1'b0;
            if (s_q.pend) begin
                s_d.level = s_q.pend_level;
                s_d.lock  = s_q.pend_lock;
                s_d.pend  = 1'b0;
            end
        end

        if (op_req_i) begin
            if (tmr_busy || !s_q.wen || req_blocked) begin
                s_d.reject = 1'b1;
            end else begin
                s_d.grant = 1'b1;
                s_d.base  = req_base;
                s_d.kind  = req_kind;
                tmr_load  = 1'b1;
                tmr_dur   = kind_dur;
            end
        end else if (sr_wr_i) begin
            if (tmr_busy || !s_q.wen || (s_q.lock && !wp_i)) begin
                s_d.reject = 1'b1;
            end else begin
                s_d.grant      = 1'b1;
                s_d.pend       = 1'b1;
                s_d.pend_level = sr_wdata_i[4:2];
                s_d.pend_lock  = sr_wdata_i[7];
                tmr_load       = 1'b1;
                tmr_dur        = D_SRW;
            end
        end else if (wen_clr_i) begin
            if (!tmr_busy) s_d.wen = 1'b0;
        end else if (wen_set_i) begin
            if (!tmr_busy) s_d.wen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o  = {s_q.lock, 2'b00, s_q.level, s_q.wen, tmr_busy};
    assign busy_o    = tmr_busy;
    assign grant_o   = s_q.grant;
    assign reject_o  = s_q.reject;
    assign op_base_o = s_q.base;
    assign op_kind_o = s_q.kind;

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sr_wr_i,
    input logic       op_req_i,
    input logic [1:0] op_kind_i,
    input logic       wp_i,
    input logic [7:0] status_o,
    input logic       busy_o,
    input logic       grant_o,
    input logic       reject_o
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:5] == 2'b00);

    a_r12_grant_xor_reject: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && reject_o));

    a_r12_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> busy_o);

    a_r9_wen_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !status_o[1]);

    a_r10_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (op_req_i || sr_wr_i)) |=> reject_o);

    a_r4_no_wen_reject: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_req_i || sr_wr_i) && !status_o[1]) |=> reject_o);

    a_r7_lock_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i && !op_req_i && status_o[7] && !wp_i) |=> reject_o);

    a_r6_chip_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req_i && op_kind_i == 2'b11 && status_o[4:2] != 3'b000) |=> reject_o);

endmodule

bind flash_stat_guard fsg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_wr_i   (sr_wr_i),
    .op_req_i  (op_req_i),
    .op_kind_i (op_kind_i),
    .wp_i      (wp_i),
    .status_o  (status_o),
    .busy_o    (busy_o),
    .grant_o   (grant_o),
    .reject_o  (reject_o)
);

// File: tb/flash_stat_guard_bench.sv
module flash_stat_guard_bench;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen_set = 1'b0, wen_clr = 1'b0, sr_wr = 1'b0, op_req = 1'b0, wp = 1'b1;
    logic [7:0]    sr_data = '0;
    logic [1:0]    op_kind = '0;
    logic [AW-1:0] op_addr = '0;
    logic [7:0]    status;
    logic          busy, grant, reject;
    logic [AW-1:0] base;
    logic [1:0]    kind_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_stat_guard u_flash_stat_guard (
        .clk(clk), .rst_n(rst_n), .wen_set_i(wen_set), .wen_clr_i(wen_clr),
        .sr_wr_i(sr_wr), .sr_wdata_i(sr_data), .op_req_i(op_req),
        .op_kind_i(op_kind), .op_addr_i(op_addr), .wp_i(wp),
        .status_o(status), .busy_o(busy), .grant_o(grant), .reject_o(reject),
        .op_base_o(base), .op_kind_o(kind_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic set_wen();
        wen_set = 1'b1; @(negedge clk); wen_set = 1'b0;
    endtask

    task automatic clr_wen();
        wen_clr = 1'b1; @(negedge clk); wen_clr = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] k, input logic [AW-1:0] a);
        op_kind = k; op_addr = a; op_req = 1'b1;
        @(negedge clk); op_req = 1'b0;
    endtask

    task automatic do_srw(input logic [7:0] d);
        sr_data = d; sr_wr = 1'b1;
        @(negedge clk); sr_wr = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic load_level(input logic [7:0] d);
        int n;
        wp = 1'b1;
        set_wen();
        do_srw(d);
        chk_eq("R7 grant with pin high", grant, 1);
        wait_idle(n);
        chk_eq("R8 status after write", status, {d[7], 2'b00, d[4:2], 2'b00});
    endtask

    task automatic t_reset();
        chk_eq("R1 status", status, 8'h00);
        chk_eq("R1 busy", busy, 0);
        chk_eq("R1 grant/reject", {grant, reject}, 0);
    endtask

    task automatic t_latch();
        set_wen();
        chk_eq("R3 set", status, 8'h02);
        clr_wen();
        chk_eq("R3 clear", status, 8'h00);
        wen_set = 1'b1; wen_clr = 1'b1; @(negedge clk); wen_set = 1'b0; wen_clr = 1'b0;
        chk_eq("R3 clear wins", status, 8'h00);
    endtask

    task automatic t_no_wen();
        do_op(2'b00, 19'h01000);
        chk_eq("R4 reject", reject, 1);
        chk_eq("R4 busy", busy, 0);
        chk_eq("R4 status", status, 8'h00);
        do_srw(8'h1C);
        chk_eq("R4 srw reject", reject, 1);
        @(negedge clk);
        chk_eq("R4 level unchanged", status, 8'h00);
    endtask

    task automatic t_ops();
        int n;
        set_wen();
        do_op(2'b00, 19'h12345);
        chk_eq("R12 grant pulse", {grant, reject}, 2'b10);
        chk_eq("R11 program base", base, 19'h12345);
        chk_eq("R2 busy bit", status, 8'h03);
        wait_idle(n);
        chk_eq("R9 program cycles", n, 6);
        chk_eq("R9 latch cleared", status, 8'h00);
        chk_eq("R12 grant gone", grant, 0);
        set_wen();
        do_op(2'b01, 19'h12345);
        chk_eq("R11 small-sector base", base, 19'h12000);
        chk_eq("R11 kind", kind_o, 2'b01);
        wait_idle(n);
        chk_eq("R9 small-sector cycles", n, 10);
    endtask

    task automatic t_busy();
        int n;
        set_wen();
        do_op(2'b10, 19'h1ABCD);
        chk_eq("R11 sector base", base, 19'h10000);
        do_op(2'b00, 19'h00010);
        chk_eq("R10 reject while busy", reject, 1);
        chk_eq("R10 base unchanged", base, 19'h10000);
        clr_wen();
        chk_eq("R3 clear ignored while busy", status[1], 1);
        do_srw(8'h1C);
        chk_eq("R10 srw reject while busy", reject, 1);
        wait_idle(n);
        chk_eq("R9 sector cycles", n, 11);
        chk_eq("R10 level unchanged", status, 8'h00);
    endtask

    task automatic t_status_write();
        int n;
        wp = 1'b1;
        set_wen();
        do_srw(8'hFF);
        chk_eq("R8 pending not shown", status, 8'h03);
        wait_idle(n);
        chk_eq("R9 srw cycles", n, 5);
        chk_eq("R8 only level and lock", status, 8'h9C);
        wp = 1'b0;
        set_wen();
        do_srw(8'h00);
        chk_eq("R7 locked reject", reject, 1);
        chk_eq("R7 latch kept", status, 8'h9E);
        wp = 1'b1;
        do_srw(8'h04);
        chk_eq("R7 pin high grants", grant, 1);
        wait_idle(n);
        chk_eq("R8 unlock", status, 8'h04);
    endtask

    task automatic probe(input string req, input logic [1:0] k, input logic [AW-1:0] a, input bit ok);
        int n;
        set_wen();
        do_op(k, a);
        chk_eq(req, grant, ok);
        if (!ok) chk_eq("R5 latch kept on reject", status[1], 1);
        wait_idle(n);
        clr_wen();
    endtask

    task automatic t_protect();
        int n;
        load_level(8'h04);
        probe("R5 001 below", 2'b00, 19'h6FFFF, 1);
        probe("R5 001 at", 2'b00, 19'h70000, 0);
        probe("R5 001 small sector", 2'b01, 19'h7F000, 0);
        probe("R6 chip at 001", 2'b11, 19'h00000, 0);
        load_level(8'h08);
        probe("R5 010 below", 2'b00, 19'h5FFFF, 1);
        probe("R5 010 at", 2'b00, 19'h60000, 0);
        load_level(8'h0C);
        probe("R5 011 below", 2'b00, 19'h3FFFF, 1);
        probe("R5 011 sector", 2'b10, 19'h40000, 0);
        load_level(8'h10);
        probe("R5 1xx whole", 2'b00, 19'h00000, 0);
        load_level(8'h00);
        set_wen();
        do_op(2'b11, 19'h12345);
        chk_eq("R6 chip granted", grant, 1);
        chk_eq("R11 chip base", base, 19'h00000);
        wait_idle(n);
        chk_eq("R9 chip cycles", n, 20);
    endtask

    task automatic t_both();
        int n;
        wp = 1'b1;
        set_wen();
        op_kind = 2'b00; op_addr = 19'h00200; op_req = 1'b1;
        sr_data = 8'h10; sr_wr = 1'b1;
        @(negedge clk); op_req = 1'b0; sr_wr = 1'b0;
        chk_eq("R13 array op handled", base, 19'h00200);
        wait_idle(n);
        chk_eq("R13 status write dropped", status, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_no_wen();
        t_ops();
        t_busy();
        t_status_write();
        t_protect();
        t_both();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule